// File: doc/BRIEF.md
# Phase-Shifted Carrier PWM Generator

This block produces the insert/bypass commands for every sub-module of one converter leg. The leg has `N_SM` sub-modules in its upper arm and `N_SM` in its lower arm. Each sub-module owns a symmetric triangular carrier. All carriers share one period and one amplitude, and their phases are spread evenly around the carrier period. A sub-module is inserted while its signed reference lies above its carrier and is bypassed while the reference lies below it. An arm can therefore present from 0 to `N_SM` inserted modules, which gives `N_SM`+1 levels. The carrier period is chosen by software so that it is not an integer multiple of the fundamental; for example 447 Hz with four modules per arm, or 247 Hz with forty.

References arrive as a stream. Each transfer is one word that holds a signed reference for every sub-module. Slot k (0 ≤ k < `N_SM`) carries upper module k and slot `N_SM`+k carries lower module k. The block holds one word in a pending buffer. `ref_ready_o` stays low while that buffer is occupied, which is the back-pressure an upstream controller must respect. While the generator runs, the pending word takes effect at the carrier peak of upper module 0. That peak is also signalled on `peak_o`, so a controller can time its next update from it. While the generator is disabled, a pending word takes effect one cycle after it is accepted.

Top module: `psc_pwm_leg`

## Requirements
- R1: Each carrier is a counter c that moves one step per enabled cycle between 0 and P, rising and then falling, so that one carrier period lasts 2P cycles. The comparator sees c as the signed value 2c−P, which spans −P to +P.
- R2: Within the upper arm, the carrier of module k leads the carrier of module 0 by floor(k·2P/`N_SM`) cycles (modulo 2P).
- R3: When `N_SM` is odd, lower module k has the same carrier phase as upper module k. When `N_SM` is even, lower module k leads upper module 0 by floor((2k+1)·P/`N_SM`) cycles, which is an extra P/`N_SM` (π/`N_SM`).
- R4: An insert output becomes 1 when its reference is above its carrier value, becomes 0 when the reference is below it, and keeps its previous value when the two are equal. With a constant reference r, a module is therefore inserted for min(max(P+r, 0), 2P) cycles out of every 2P.
- R5: While disabled, every insert output is 0 and `peak_o` is 0. Re-enabling restarts every carrier from its phase offset.
- R6: While enabled, `peak_o` is high for exactly one cycle, when the carrier of upper module 0 is at P, and so pulses once every 2P cycles.
- R7: P is taken from `period_i` only while `en_i` is low. A change to `period_i` while enabled has no effect until the next enable. A setting below 2 is used as 2.
- R8: `ref_ready_o` is high exactly when the pending buffer is empty, and it drops in the cycle after a handshake. While enabled, the pending word becomes active in the cycle where `peak_o` is high, and `ref_ready_o` rises in the next cycle. While disabled, `ref_ready_o` rises two cycles after the handshake.
- R9: After reset, all insert outputs and `peak_o` are 0, `ref_ready_o` is 1, and every active reference is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low bypasses all modules |
| period_i | input | CNT_W | Carrier half-period P in cycles |
| ref_valid_i | input | 1 | Reference word offered |
| ref_ready_o | output | 1 | Pending buffer empty, word can be taken |
| ref_data_i | input | 2·N_SM·REF_W | Signed references, one per slot |
| ins_up_o | output | N_SM | Insert commands, upper arm |
| ins_lo_o | output | N_SM | Insert commands, lower arm |
| peak_o | output | 1 | Upper module 0 carrier at its peak |

## Verification
The bench builds two copies of the block. The first has `N_SM`=4 with P=8, so every phase offset is a whole number of cycles and the extra π/n shift of the even lower arm can be measured exactly. The second has `N_SM`=3 with P=9, which brings the odd case within reach, where the lower arm must track the upper arm. The small P keeps a full carrier period at 16 or 18 cycles. This lets duty counts at the carrier extremes, equality holds, period latching and the clamp to 2 each be checked within a few hundred cycles.

// File: rtl/psc_pkg.sv
package psc_pkg;

  typedef enum logic {
    ARM_UPPER = 1'b0,
    ARM_LOWER = 1'b1
  } arm_e;

  // Phase offset, in units of P/N cycles, for module idx of the given arm.
  function automatic int unsigned phase_mult(input int unsigned idx,
                                             input arm_e arm,
                                             input int unsigned n);
    int unsigned extra;
    extra = ((arm == ARM_LOWER) && ((n % 2) == 0)) ? 1 : 0;
    return 2 * idx + extra;
  endfunction

endpackage

// File: rtl/psc_phase_init.sv
module psc_phase_init
  import psc_pkg::*;
#(
  parameter int unsigned N_SM  = 4,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned IDX   = 0,
  parameter arm_e        ARM   = ARM_UPPER
) (
  input  logic [CNT_W-1:0] p_lim,
  output logic [CNT_W-1:0] start_cnt,
  output logic             start_up
);
  localparam int unsigned MULT  = phase_mult(IDX, ARM, N_SM);
  localparam int unsigned POS_W = CNT_W + $clog2(2 * N_SM) + 1;

  logic [POS_W-1:0] num;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] span;

  // Position inside the 2P-cycle period, folded onto the triangle.
  always_comb begin
    num  = POS_W'(p_lim) * POS_W'(MULT);
    pos  = num / POS_W'(N_SM);
    span = POS_W'(p_lim) << 1;
    if (pos < POS_W'(p_lim)) begin
      start_cnt = CNT_W'(pos);
      start_up  = 1'b1;
    end else begin
      start_cnt = CNT_W'(span - pos);
      start_up  = 1'b0;
    end
  end

endmodule

// File: rtl/psc_carrier.sv
module psc_carrier #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] p_lim,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic             start_up,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;
  logic             up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (!run) begin
      cnt_q <= start_cnt;
      up_q  <= start_up;
    end else if (up_q) begin
      if (cnt_q >= p_lim - CNT_W'(1)) begin
        cnt_q <= p_lim;
        up_q  <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end else begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_q <= '0;
        up_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign cnt = cnt_q;

  AST_CAR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= p_lim)); // R1

  AST_CAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |->
      ((cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))) ||
       (cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1))))); // R1

endmodule

// File: rtl/psc_cmp.sv
module psc_cmp #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned REF_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic signed [REF_W-1:0] ref_val,
  input  logic [CNT_W-1:0]        cnt,
  input  logic [CNT_W-1:0]        p_lim,
  output logic                    ins
);
  localparam int unsigned CMP_W = ((REF_W > CNT_W + 2) ? REF_W : CNT_W + 2) + 1;

  logic signed [CMP_W-1:0] car_s;
  logic signed [CMP_W-1:0] ref_s;
  logic                    ins_q;

  always_comb begin
    car_s = $signed(CMP_W'(cnt) << 1) - $signed(CMP_W'(p_lim));
    ref_s = CMP_W'(ref_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q <= 1'b0;
    end else if (!run) begin
      ins_q <= 1'b0;
    end else if (ref_s > car_s) begin
      ins_q <= 1'b1;
    end else if (ref_s < car_s) begin
      ins_q <= 1'b0;
    end
  end

  assign ins = ins_q;

  AST_IDLE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !ins_q); // R5

endmodule

// File: rtl/psc_pwm_leg.sv
module psc_pwm_leg
  import psc_pkg::*;
#(
  parameter int unsigned N_SM  = 4,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned REF_W = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en_i,
  input  logic [CNT_W-1:0]              period_i,
  input  logic                          ref_valid_i,
  output logic                          ref_ready_o,
  input  logic [2*N_SM*REF_W-1:0]       ref_data_i,
  output logic [N_SM-1:0]               ins_up_o,
  output logic [N_SM-1:0]               ins_lo_o,
  output logic                          peak_o
);
  localparam int unsigned SLOT_N = 2 * N_SM;
  localparam int unsigned DATA_W = SLOT_N * REF_W;

  logic              run_q;
  logic [CNT_W-1:0]  p_q;
  logic [DATA_W-1:0] pend_q;
  logic [DATA_W-1:0] act_q;
  logic              pend_full_q;
  logic              acc;
  logic              xfer;
  logic              peak;
  logic [CNT_W-1:0]  cnt_w [SLOT_N];
  logic [SLOT_N-1:0] ins_w;

  // Run flag and half-period latch (latched only while disabled).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      p_q   <= CNT_W'(2);
    end else begin
      run_q <= en_i;
      if (!en_i) begin
        p_q <= (period_i < CNT_W'(2)) ? CNT_W'(2) : period_i;
      end
    end
  end

  assign peak = run_q && (cnt_w[0] == p_q);
  assign acc  = ref_valid_i && !pend_full_q;
  assign xfer = pend_full_q && (!run_q || peak);

  // Pending / active reference buffers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= '0;
      act_q       <= '0;
      pend_full_q <= 1'b0;
    end else begin
      if (acc) begin
        pend_q      <= ref_data_i;
        pend_full_q <= 1'b1;
      end else if (xfer) begin
        act_q       <= pend_q;
        pend_full_q <= 1'b0;
      end
    end
  end

  assign ref_ready_o = !pend_full_q;
  assign peak_o      = peak;

  for (genvar a = 0; a < 2; a++) begin : g_arm
    for (genvar k = 0; k < N_SM; k++) begin : g_mod
      localparam int unsigned S = a * N_SM + k;

      logic [CNT_W-1:0] st_cnt;
      logic             st_up;

      psc_phase_init #(
        .N_SM (N_SM),
        .CNT_W(CNT_W),
        .IDX  (k),
        .ARM  ((a == 0) ? ARM_UPPER : ARM_LOWER)
      ) u_init (
        .p_lim    (p_q),
        .start_cnt(st_cnt),
        .start_up (st_up)
      );

      psc_carrier #(
        .CNT_W(CNT_W)
      ) u_car (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .p_lim    (p_q),
        .start_cnt(st_cnt),
        .start_up (st_up),
        .cnt      (cnt_w[S])
      );

      psc_cmp #(
        .CNT_W(CNT_W),
        .REF_W(REF_W)
      ) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_q),
        .ref_val($signed(act_q[S*REF_W +: REF_W])),
        .cnt    (cnt_w[S]),
        .p_lim  (p_q),
        .ins    (ins_w[S])
      );
    end
  end

  assign ins_up_o = ins_w[N_SM-1:0];
  assign ins_lo_o = ins_w[SLOT_N-1:N_SM];

  if ((N_SM % 2) == 1) begin : g_odd
    for (genvar k = 0; k < N_SM; k++) begin : g_chk
      AST_ARM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_w[k] == cnt_w[N_SM + k])); // R3
    end
  end

  AST_PEAK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    peak_o |=> !peak_o); // R6

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_valid_i && ref_ready_o) |=> !ref_ready_o); // R8

  AST_IDLE_NO_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !$past(en_i)) |-> !peak_o); // R5

endmodule

// File: tb/psc_pwm_leg_bench.sv
`timescale 1ns/1ps
module psc_pwm_leg_bench;
  localparam int NA = 4;
  localparam int NB = 3;
  localparam int CW = 8;
  localparam int RW = 10;
  localparam int PA = 8;
  localparam int PB = 9;
  localparam int VEC_N = 9;
  // {reference, expected inserted cycles per 16-cycle period at P=8}
  localparam int VEC [VEC_N][2] = '{
    '{0, 8}, '{2, 10}, '{3, 11}, '{-5, 3}, '{8, 16},
    '{9, 16}, '{-8, 0}, '{-20, 0}, '{-1, 7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              en_a = 1'b0, vld_a = 1'b0, rdy_a, peak_a;
  logic [CW-1:0]     period_a = CW'(PA);
  logic [2*NA*RW-1:0] data_a = '0;
  logic [NA-1:0]     up_a, lo_a;
  logic              en_b = 1'b0, rdy_b, peak_b;
  logic [CW-1:0]     period_b = CW'(PB);
  logic [2*NB*RW-1:0] data_b = '0;
  logic [NB-1:0]     up_b, lo_b;

  psc_pwm_leg #(.N_SM(NA), .CNT_W(CW), .REF_W(RW)) u_psc_pwm_leg (
    .clk(clk), .rst_n(rst_n), .en_i(en_a), .period_i(period_a),
    .ref_valid_i(vld_a), .ref_ready_o(rdy_a), .ref_data_i(data_a),
    .ins_up_o(up_a), .ins_lo_o(lo_a), .peak_o(peak_a));

  psc_pwm_leg #(.N_SM(NB), .CNT_W(CW), .REF_W(RW)) u_psc_pwm_leg_odd (
    .clk(clk), .rst_n(rst_n), .en_i(en_b), .period_i(period_b),
    .ref_valid_i(1'b0), .ref_ready_o(rdy_b), .ref_data_i(data_b),
    .ins_up_o(up_b), .ins_lo_o(lo_b), .peak_o(peak_b));

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int hi_a [2*NA];
  int last_a [2*NA];
  int last_b [2*NB];

  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit bit_a(input int s);
    return (s < NA) ? up_a[s] : lo_a[s-NA];
  endfunction

  function automatic bit bit_b(input int s);
    return (s < NB) ? up_b[s] : lo_b[s-NB];
  endfunction

  task automatic send_all(input int r);
    @(negedge clk);
    for (int w = 0; w < 1000 && !rdy_a; w++) @(negedge clk);
    for (int s = 0; s < 2*NA; s++) data_a[s*RW +: RW] = RW'(r);
    vld_a = 1'b1;
    @(negedge clk);
    vld_a = 1'b0;
  endtask

  task automatic wait_peak();
    @(negedge clk);
    for (int w = 0; w < 1000 && !peak_a; w++) @(negedge clk);
  endtask

  task automatic peak_gap(output int gap);
    int n;
    n = 0;
    wait_peak();
    do begin
      @(negedge clk);
      n++;
    end while (!peak_a && n < 1000);
    gap = n;
  endtask

  task automatic measure_duty();
    for (int s = 0; s < 2*NA; s++) hi_a[s] = 0;
    for (int c = 0; c < 2*PA; c++) begin
      @(negedge clk);
      for (int s = 0; s < 2*NA; s++) hi_a[s] += int'(bit_a(s));
    end
  endtask

  task automatic measure_rises();
    bit pa [2*NA];
    bit pb [2*NB];
    @(negedge clk);
    for (int s = 0; s < 2*NA; s++) begin pa[s] = bit_a(s); last_a[s] = -1; end
    for (int s = 0; s < 2*NB; s++) begin pb[s] = bit_b(s); last_b[s] = -1; end
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      for (int s = 0; s < 2*NA; s++) begin
        if (bit_a(s) && !pa[s]) last_a[s] = cyc;
        pa[s] = bit_a(s);
      end
      for (int s = 0; s < 2*NB; s++) begin
        if (bit_b(s) && !pb[s]) last_b[s] = cyc;
        pb[s] = bit_b(s);
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int gap;
    int lead;
    int cnt;
    // R9: reset state
    repeat (3) @(negedge clk);
    chk(up_a == '0 && lo_a == '0, "R9 inserts in reset", int'({up_a, lo_a}), 0);
    chk(peak_a == 1'b0, "R9 peak in reset", int'(peak_a), 0);
    chk(rdy_a == 1'b1, "R9 ready in reset", int'(rdy_a), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(up_a == '0 && lo_a == '0, "R5 disabled inserts", int'({up_a, lo_a}), 0);

    en_a = 1'b1;
    en_b = 1'b1;
    repeat (2*PB + 4) @(negedge clk);

    // R2 / R3: phase leads, reference 0 is active since reset (R9)
    measure_rises();
    for (int k = 1; k < NA; k++) begin
      lead = (((last_a[0] - last_a[k]) % (2*PA)) + 2*PA) % (2*PA);
      chk(lead == 4*k, "R2 upper lead even arm", lead, 4*k);
    end
    for (int k = 0; k < NA; k++) begin
      lead = (((last_a[0] - last_a[NA+k]) % (2*PA)) + 2*PA) % (2*PA);
      chk(lead == 4*k + 2, "R3 even lower lead", lead, 4*k + 2);
    end
    for (int k = 1; k < NB; k++) begin
      lead = (((last_b[0] - last_b[k]) % (2*PB)) + 2*PB) % (2*PB);
      chk(lead == 6*k, "R2 upper lead odd arm", lead, 6*k);
    end
    for (int k = 0; k < NB; k++) begin
      chk(last_b[NB+k] == last_b[k], "R3 odd lower tracks upper", last_b[NB+k], last_b[k]);
    end

    // R6 / R1: peak once per 2P cycles
    peak_gap(gap);
    chk(gap == 2*PA, "R6 peak interval", gap, 2*PA);
    cnt = 0;
    for (int c = 0; c < 8*PA; c++) begin
      @(negedge clk);
      cnt += int'(peak_a);
    end
    chk(cnt == 4, "R1 peaks in four periods", cnt, 4);

    // Vector walk: R4 duty, R8 back-pressure and apply-at-peak
    for (int v = 0; v < VEC_N; v++) begin
      send_all(VEC[v][0]);
      chk(rdy_a == 1'b0, "R8 ready low after handshake", int'(rdy_a), 0);
      wait_peak();
      chk(rdy_a == 1'b0, "R8 still pending at peak", int'(rdy_a), 0);
      @(negedge clk);
      chk(rdy_a == 1'b1, "R8 ready after peak", int'(rdy_a), 1);
      repeat (2*PA + 2) @(negedge clk);
      measure_duty();
      for (int s = 0; s < 2*NA; s++) begin
        chk(hi_a[s] == VEC[v][1], "R4 inserted cycles per period", hi_a[s], VEC[v][1]);
      end
    end

    // R7: period change ignored while enabled
    period_a = CW'(12);
    repeat (3) @(negedge clk);
    peak_gap(gap);
    chk(gap == 2*PA, "R7 period held while enabled", gap, 2*PA);

    // R5: disable clears outputs
    en_a = 1'b0;
    repeat (3) @(negedge clk);
    chk(up_a == '0 && lo_a == '0, "R5 inserts cleared", int'({up_a, lo_a}), 0);
    chk(peak_a == 1'b0, "R5 peak quiet", int'(peak_a), 0);
    en_a = 1'b1;
    peak_gap(gap);
    chk(gap == 24, "R7 new period after re-enable", gap, 24);

    // R7: clamp to 2
    en_a = 1'b0;
    period_a = CW'(1);
    repeat (3) @(negedge clk);
    en_a = 1'b1;
    peak_gap(gap);
    chk(gap == 4, "R7 period clamp", gap, 4);

    // R8: disabled path, then confirm the word is active
    en_a = 1'b0;
    period_a = CW'(PA);
    repeat (3) @(negedge clk);
    send_all(4);
    chk(rdy_a == 1'b0, "R8 ready low while disabled", int'(rdy_a), 0);
    @(negedge clk);
    chk(rdy_a == 1'b1, "R8 disabled transfer", int'(rdy_a), 1);
    en_a = 1'b1;
    repeat (2*PA + 2) @(negedge clk);
    measure_duty();
    for (int s = 0; s < 2*NA; s++) begin
      chk(hi_a[s] == 12, "R8 word applied while disabled", hi_a[s], 12);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule